// File: doc/BRIEF.md
# Vector-Unit Exception Detect and Vector

This block sits where instructions move from issue to completion in an in-order core with a SIMD vector unit. Each cycle it looks at the instruction being issued. It uses the decoded class flags, the current machine-state bits, the MMU's translation result for vector memory accesses, and the vector FPU's denormal flag. From these it decides whether one precise exception must be taken.

Three causes are possible:
- **Vector-unit-unavailable**: the vector unit is switched off.
- **Data storage**: a vector load or store hits a translation fault.
- **Vector floating-point assist**: a denormal value is seen in Java mode.

When more than one cause applies, only the highest-priority one is reported. When an exception is taken, the block drops younger instructions in the same cycle. On the next clock edge it does four things: saves the faulting address and the machine-state bits, forces supervisor mode, produces the handler address, and pulses the save strobes. A return strobe later restores the saved machine-state bits.

The block holds the machine-state register (MSR) itself. Software loads it through a write port. The current value is always visible at the output.

MSR bit layout:

| Bit | Meaning |
|-----|---------|
| 3 | vector-enable |
| 2 | interrupt-prefix |
| 1 | Java mode |
| 0 | problem state (1 = user, 0 = supervisor) |

Top module: `vxc_unit`

## Requirements
- R1: A valid vector instruction raises cause 1 (unavailable) when MSR vector-enable is 0, unless it is a data-stream instruction or a save-mask register access. Its handler offset is 0x00F20.
- R2: Data-stream instructions (touch, touch-for-store, stop, stop-all, marked by `op_stream`) never raise cause 1, whatever vector-enable is.
- R3: An access to the vector save-mask register (`op_vsave`) never raises cause 1.
- R4: The handler address is the cause offset plus a base. The base is 0x00000000 when MSR interrupt-prefix is 0 and 0xFFF00000 when it is 1. The prefix used is the one in force when the exception is detected.
- R5: A valid vector load/store (`op_vmem`) raises cause 2 (data storage, offset 0x00300) only when the MMU reports no valid PTE, a protection violation, or a direct-store (T=1) segment.
- R6: When cause 2 is taken, `dfault_status` is updated as follows: bit0 = no PTE, bit1 = protection, bit2 = direct-store, bit3 = the access was a store. Otherwise it holds its value.
- R7: A valid vector FP instruction (`op_vfp`) with `fpu_denorm` raises cause 3 (assist, offset 0x01600) only when MSR Java mode is 1.
- R8: When several causes apply, priority is 1 over 2 over 3. `exc_cause` is 0 when no exception was taken.
- R9: An exception detected in cycle N produces the following one cycle later:
  - `exc_taken`, `save_pc_we` and `save_msr_we` high for one cycle;
  - `save_pc` set to that instruction's address;
  - `save_msr` set to the MSR before entry;
  - MSR problem state cleared, with the other MSR bits unchanged.
- R10: `flush_younger` is high combinationally in the same cycle that the exception is detected.
- R11: `rfi` with no exception that cycle loads the MSR from `save_msr` on the next edge. An exception wins over `rfi`, and `rfi` wins over `msr_load`.
- R12: Synchronous active-high reset clears the MSR, the saved values, the fault status and all exception outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is at the issue/complete point |
| issue_pc | input | 32 | Address of that instruction |
| op_vec | input | 1 | Instruction belongs to the vector unit |
| op_stream | input | 1 | Data-stream touch/stop instruction |
| op_vsave | input | 1 | Access to the vector save-mask register |
| op_vmem | input | 1 | Vector load or store |
| op_store | input | 1 | The vector memory access is a store |
| op_vfp | input | 1 | Vector floating-point instruction |
| mmu_no_pte | input | 1 | Table search found no valid entry |
| mmu_prot | input | 1 | Protection violation |
| mmu_direct | input | 1 | Target is a direct-store segment |
| fpu_denorm | input | 1 | Denormal input or output seen |
| rfi | input | 1 | Return-from-interrupt strobe |
| msr_load | input | 1 | Write MSR from `msr_load_val` |
| msr_load_val | input | 4 | New MSR value |
| msr_out | output | 4 | Current MSR |
| flush_younger | output | 1 | Drop younger instructions (same cycle) |
| exc_taken | output | 1 | Exception-taken pulse |
| exc_cause | output | 2 | Cause code: 0 none, 1 unavailable, 2 data storage, 3 assist |
| exc_vector | output | 32 | Handler address |
| save_pc_we | output | 1 | Return-address save strobe |
| save_pc | output | 32 | Saved return address |
| save_msr_we | output | 1 | Machine-state save strobe |
| save_msr | output | 4 | Saved MSR |
| dfault_status | output | 4 | Data-storage fault status |

## Verification
The reference model is driven hard on overlapping causes. Examples are a faulting vector load issued with the unit disabled, and a denormal seen outside Java mode. A design with the priority inverted, or a denormal trap that ignores Java mode, would report the wrong cause code. Stream and save-mask instructions are issued with vector-enable clear. A design missing either exemption would raise a spurious unavailable exception. The bench also exercises both prefix settings, an exception colliding with `rfi`, and `rfi` following a trap. These catch a wrong base address, a return strobe that beats the exception, and a restore that loses the vector-enable or privilege bit.

// File: rtl/vxc_pkg.sv
package vxc_pkg;
    parameter int ADDR_W = 32;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_UNAVAIL = 2'd1,
        CAUSE_DSTORE  = 2'd2,
        CAUSE_ASSIST  = 2'd3
    } cause_e;

    typedef struct packed {
        logic vec_en;
        logic prefix;
        logic java;
        logic prob;
    } msr_t;

    typedef struct packed {
        logic valid;
        logic vec;
        logic stream;
        logic vsave;
        logic vmem;
        logic store;
        logic vfp;
    } op_t;

    typedef struct packed {
        logic no_pte;
        logic prot;
        logic direct;
    } mmu_t;

    typedef struct packed {
        logic store;
        logic direct;
        logic prot;
        logic no_pte;
    } fstat_t;

    localparam logic [ADDR_W-1:0] HIGH_BASE   = 32'hFFF0_0000;
    localparam logic [ADDR_W-1:0] OFF_UNAVAIL = 32'h0000_0F20;
    localparam logic [ADDR_W-1:0] OFF_DSTORE  = 32'h0000_0300;
    localparam logic [ADDR_W-1:0] OFF_ASSIST  = 32'h0000_1600;

    function automatic logic [ADDR_W-1:0] cause_offset(cause_e c);
        case (c)
            CAUSE_UNAVAIL: return OFF_UNAVAIL;
            CAUSE_DSTORE:  return OFF_DSTORE;
            CAUSE_ASSIST:  return OFF_ASSIST;
            default:       return '0;
        endcase
    endfunction
endpackage

// File: rtl/vxc_cause.sv
module vxc_cause
    import vxc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  op_t    op,
    input  mmu_t   mmu,
    input  logic   denorm,
    input  msr_t   msr,
    output cause_e cause,
    output fstat_t fstat
);
    logic hit_unavail, hit_dstore, hit_assist;
    logic sel_unavail, sel_dstore, sel_assist;

    always_comb begin
        hit_unavail = op.valid && op.vec && !op.stream && !op.vsave && !msr.vec_en;
        hit_dstore  = op.valid && op.vec && op.vmem &&
                      (mmu.no_pte || mmu.prot || mmu.direct);
        hit_assist  = op.valid && op.vec && op.vfp && denorm && msr.java;
        sel_unavail = hit_unavail;
        sel_dstore  = hit_dstore && !hit_unavail;
        sel_assist  = hit_assist && !hit_unavail && !hit_dstore;
        if (sel_unavail)     cause = CAUSE_UNAVAIL;
        else if (sel_dstore) cause = CAUSE_DSTORE;
        else if (sel_assist) cause = CAUSE_ASSIST;
        else                 cause = CAUSE_NONE;
        fstat.no_pte = mmu.no_pte;
        fstat.prot   = mmu.prot;
        fstat.direct = mmu.direct;
        fstat.store  = op.store;
    end

    // R8
    one_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_unavail, sel_dstore, sel_assist}));

    // R2
    stream_exempt_chk: assert property (@(posedge clk) disable iff (rst)
        (op.stream || op.vsave) |-> cause != CAUSE_UNAVAIL);
endmodule

// File: rtl/vxc_vecgen.sv
module vxc_vecgen
    import vxc_pkg::*;
(
    input  cause_e              cause,
    input  logic                prefix,
    output logic [ADDR_W-1:0]   vec_addr
);
    logic [ADDR_W-1:0] base;

    always_comb begin
        base     = prefix ? HIGH_BASE : '0;
        vec_addr = (cause == CAUSE_NONE) ? '0 : (base | cause_offset(cause));
    end
endmodule

// File: rtl/vxc_state.sv
module vxc_state
    import vxc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [ADDR_W-1:0] pc,
    input  logic              rfi,
    input  logic              load,
    input  msr_t              load_val,
    output msr_t              msr_q,
    output msr_t              srr1_q,
    output logic [ADDR_W-1:0] srr0_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            msr_q  <= '0;
            srr1_q <= '0;
            srr0_q <= '0;
        end else if (take) begin
            srr0_q     <= pc;
            srr1_q     <= msr_q;
            msr_q.prob <= 1'b0;
        end else if (rfi) begin
            msr_q <= srr1_q;
        end else if (load) begin
            msr_q <= load_val;
        end
    end

    // R11
    rfi_restore_chk: assert property (@(posedge clk) disable iff (rst)
        (rfi && !take) |=> msr_q == $past(srr1_q));

    // R9
    sup_entry_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (!msr_q.prob && srr1_q == $past(msr_q)));
endmodule

// File: rtl/vxc_unit.sv
module vxc_unit
    import vxc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        issue_valid,
    input  logic [31:0] issue_pc,
    input  logic        op_vec,
    input  logic        op_stream,
    input  logic        op_vsave,
    input  logic        op_vmem,
    input  logic        op_store,
    input  logic        op_vfp,
    input  logic        mmu_no_pte,
    input  logic        mmu_prot,
    input  logic        mmu_direct,
    input  logic        fpu_denorm,
    input  logic        rfi,
    input  logic        msr_load,
    input  logic [3:0]  msr_load_val,
    output logic [3:0]  msr_out,
    output logic        flush_younger,
    output logic        exc_taken,
    output logic [1:0]  exc_cause,
    output logic [31:0] exc_vector,
    output logic        save_pc_we,
    output logic [31:0] save_pc,
    output logic        save_msr_we,
    output logic [3:0]  save_msr,
    output logic [3:0]  dfault_status
);
    op_t               op;
    mmu_t              mmu;
    msr_t              msr_q, srr1_q;
    cause_e            cause;
    fstat_t            fstat, fstat_q;
    logic [ADDR_W-1:0] vec_addr, srr0_q;
    logic              take;
    logic              taken_q;
    cause_e            cause_q;
    logic [ADDR_W-1:0] vector_q;

    assign op  = '{valid: issue_valid, vec: op_vec, stream: op_stream, vsave: op_vsave,
                   vmem: op_vmem, store: op_store, vfp: op_vfp};
    assign mmu = '{no_pte: mmu_no_pte, prot: mmu_prot, direct: mmu_direct};

    vxc_cause u_cause (
        .clk(clk), .rst(rst), .op(op), .mmu(mmu), .denorm(fpu_denorm),
        .msr(msr_q), .cause(cause), .fstat(fstat)
    );

    vxc_vecgen u_vecgen (.cause(cause), .prefix(msr_q.prefix), .vec_addr(vec_addr));

    assign take = (cause != CAUSE_NONE);

    vxc_state u_state (
        .clk(clk), .rst(rst), .take(take), .pc(issue_pc), .rfi(rfi),
        .load(msr_load), .load_val(msr_t'(msr_load_val)),
        .msr_q(msr_q), .srr1_q(srr1_q), .srr0_q(srr0_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_q  <= 1'b0;
            cause_q  <= CAUSE_NONE;
            vector_q <= '0;
            fstat_q  <= '0;
        end else begin
            taken_q  <= take;
            cause_q  <= cause;
            vector_q <= vec_addr;
            if (cause == CAUSE_DSTORE) fstat_q <= fstat;
        end
    end

    assign flush_younger = take;
    assign exc_taken     = taken_q;
    assign exc_cause     = cause_q;
    assign exc_vector    = vector_q;
    assign save_pc_we    = taken_q;
    assign save_msr_we   = taken_q;
    assign save_pc       = srr0_q;
    assign save_msr      = srr1_q;
    assign msr_out       = msr_q;
    assign dfault_status = fstat_q;

    // R9
    ret_addr_chk: assert property (@(posedge clk) disable iff (rst)
        flush_younger |=> (exc_taken && save_pc == $past(issue_pc)));

    // R4
    base_sel_chk: assert property (@(posedge clk) disable iff (rst)
        flush_younger |=> exc_vector[31:20] == ($past(msr_out[2]) ? 12'hFFF : 12'h000));

    // R6
    fstat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_cause != 2'd2) |-> $stable(dfault_status) || $past(rst));
endmodule

// File: tb/sim_vxc_unit.sv
module sim_vxc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 0, op_vec = 0, op_stream = 0, op_vsave = 0;
    logic        op_vmem = 0, op_store = 0, op_vfp = 0;
    logic        mmu_no_pte = 0, mmu_prot = 0, mmu_direct = 0, fpu_denorm = 0;
    logic        rfi = 0, msr_load = 0;
    logic [3:0]  msr_load_val = 0;
    logic [31:0] issue_pc = 0;
    logic [3:0]  msr_out, save_msr, dfault_status;
    logic        flush_younger, exc_taken, save_pc_we, save_msr_we;
    logic [1:0]  exc_cause;
    logic [31:0] exc_vector, save_pc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic [3:0]  m_msr = 0, m_srr1 = 0, m_fs = 0;
    logic [31:0] m_srr0 = 0, m_vec = 0;
    logic [1:0]  m_cause = 0;
    logic        m_taken = 0;

    always #4 clk = ~clk;

    vxc_unit u0 (.*);

    function automatic logic [1:0] ref_cause();
        if (!issue_valid || !op_vec) return 2'd0;
        if (!m_msr[3] && !op_stream && !op_vsave) return 2'd1;   // R1 R2 R3
        if (op_vmem && (mmu_no_pte || mmu_prot || mmu_direct)) return 2'd2; // R5
        if (op_vfp && fpu_denorm && m_msr[1]) return 2'd3;         // R7
        return 2'd0;
    endfunction

    always @(posedge clk) begin
        logic [1:0] c;
        c = ref_cause();
        if (rst) begin
            m_msr = 0; m_srr1 = 0; m_srr0 = 0; m_fs = 0;
            m_cause = 0; m_taken = 0; m_vec = 0;
        end else begin
            m_taken = (c != 0);
            m_cause = c;
            case (c)
                2'd1: m_vec = 32'h0F20;
                2'd2: m_vec = 32'h0300;
                2'd3: m_vec = 32'h1600;
                default: m_vec = 0;
            endcase
            if (c != 0 && m_msr[2]) m_vec = m_vec + 32'hFFF0_0000;
            if (c == 2'd2) m_fs = {op_store, mmu_direct, mmu_prot, mmu_no_pte};
            if (c != 0) begin
                m_srr0 = issue_pc; m_srr1 = m_msr; m_msr[0] = 1'b0;
            end else if (rfi) m_msr = m_srr1;
            else if (msr_load) m_msr = msr_load_val;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (!done) begin
        chk("R10 flush", {31'd0, flush_younger}, {31'd0, ref_cause() != 0});
        chk("R9 taken", {31'd0, exc_taken}, {31'd0, m_taken});
        chk("R9 save strobes", {30'd0, save_pc_we, save_msr_we}, {30'd0, m_taken, m_taken});
        chk("R8 cause", {30'd0, exc_cause}, {30'd0, m_cause});
        chk("R4 vector", exc_vector, m_vec);
        chk("R9 save_pc", save_pc, m_srr0);
        chk("R9 save_msr", {28'd0, save_msr}, {28'd0, m_srr1});
        chk("R11 msr", {28'd0, msr_out}, {28'd0, m_msr});
        chk("R6 fault status", {28'd0, dfault_status}, {28'd0, m_fs});
    end

    task automatic idle();
        issue_valid = 0; op_vec = 0; op_stream = 0; op_vsave = 0; op_vmem = 0;
        op_store = 0; op_vfp = 0; mmu_no_pte = 0; mmu_prot = 0; mmu_direct = 0;
        fpu_denorm = 0; rfi = 0; msr_load = 0;
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic setmsr(logic [3:0] v);
        step(); idle(); msr_load = 1; msr_load_val = v;
        step(); idle();
    endtask

    // issue: flags = {stream,vsave,vmem,store,vfp}, mmu = {nopte,prot,direct}
    task automatic issue(logic [31:0] pc, logic [4:0] f, logic [2:0] m, logic dn);
        step(); idle();
        issue_valid = 1; op_vec = 1; issue_pc = pc;
        {op_stream, op_vsave, op_vmem, op_store, op_vfp} = f;
        {mmu_no_pte, mmu_prot, mmu_direct} = m;
        fpu_denorm = dn;
        step(); idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 0;
        // R12 reset state observed by first compare
        step();
        chk("R12 reset msr", {28'd0, msr_out}, 32'd0);
        // R1 unavailable, low base
        setmsr(4'b0001);
        issue(32'h100, 5'b00000, 3'b000, 0);
        // R2 stream / R3 save-mask exempt
        setmsr(4'b0001);
        issue(32'h104, 5'b10000, 3'b000, 0);
        issue(32'h108, 5'b01000, 3'b000, 0);
        // R4 high base
        setmsr(4'b0101);
        issue(32'h10C, 5'b00000, 3'b000, 0);
        // R5 / R6 each fault kind, store and load
        setmsr(4'b1001);
        issue(32'h200, 5'b00100, 3'b100, 0);
        issue(32'h204, 5'b00110, 3'b010, 0);
        issue(32'h208, 5'b00100, 3'b001, 0);
        issue(32'h20C, 5'b00110, 3'b000, 0);
        // R7 assist only in java mode
        setmsr(4'b1001);
        issue(32'h300, 5'b00001, 3'b000, 1);
        setmsr(4'b1011);
        issue(32'h304, 5'b00001, 3'b000, 1);
        // R8 priority overlaps
        setmsr(4'b0011);
        issue(32'h400, 5'b00101, 3'b111, 1);
        setmsr(4'b1111);
        issue(32'h404, 5'b00101, 3'b100, 1);
        // R11 rfi restores, and exception beats rfi
        setmsr(4'b0111);
        issue(32'h500, 5'b00000, 3'b000, 0);
        step(); idle(); rfi = 1; step(); idle();
        step(); idle(); rfi = 1; issue_valid = 1; op_vec = 1; op_vmem = 1;
        mmu_prot = 1; issue_pc = 32'h504; step(); idle();
        // random mix
        for (int i = 0; i < 3000; i++) begin
            step(); idle();
            issue_valid = $urandom_range(0, 3) != 0;
            op_vec = $urandom_range(0, 4) != 0;
            {op_stream, op_vsave, op_vmem, op_store, op_vfp} = 5'($urandom);
            {mmu_no_pte, mmu_prot, mmu_direct} = ($urandom_range(0, 1) != 0) ? 3'($urandom) : 3'd0;
            fpu_denorm = $urandom_range(0, 1) != 0;
            issue_pc = $urandom & 32'hFFFF_FFFC;
            rfi = $urandom_range(0, 7) == 0;
            msr_load = $urandom_range(0, 3) == 0;
            msr_load_val = 4'($urandom);
        end
        step(); idle(); step();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule